// File: doc/BRIEF.md
# Sixteen-Function Bitwise Logic Unit

This block forms any one of the sixteen two-input Boolean functions of two N-bit operands and captures the result in a destination register. A 4-bit function code picks the function. The same function is applied to every bit position on its own, with no interaction between bits. A zero flag reports whether the stored result is all zeros.

The block is a single pipeline stage. When the load enable is high at a rising clock edge, the register takes the new result, and the result is visible one cycle after that edge. When the load enable is low, the register keeps its value. A synchronous reset clears the register and takes priority over a load. Operands, the code and the enable are plain control-style inputs with no handshake. A caller that needs flow control gates the load enable itself.

Top module: `logic_uop_unit`

## Requirements
- R1: A synchronous reset clears the result to all zeros and sets the zero flag. The reset wins over a load in the same cycle.
- R2: While load_en is low, the result and the zero flag keep their values whatever the operands and code do.
- R3: Code 0 loads all zeros, and code 15 loads all ones.
- R4: Code 1 gives A AND B, code 7 gives A OR B, code 6 gives A XOR B, and code 9 gives A XNOR B.
- R5: Code 8 gives NOR of A and B, and code 14 gives NAND of A and B.
- R6: Code 3 passes A, code 5 passes B, code 12 gives NOT A, and code 10 gives NOT B.
- R7: Code 2 gives A AND NOT B, code 4 gives NOT A AND B, code 11 gives A OR NOT B, and code 13 gives NOT A OR B.
- R8: Each result bit is the code bit at index {~a,~b}. With A = 0xCCCC and B = 0xAAAA (16 bits), every nibble of the result therefore equals the code with its four bits reversed.
- R9: The zero flag is high exactly when the stored result is all zeros.
- R10: A load sampled at a rising edge appears on the result in the cycle that follows that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Load the computed function into the destination register |
| func | input | 4 | Function code, 0 to 15 |
| opa | input | WIDTH | Operand A |
| opb | input | WIDTH | Operand B |
| result | output | WIDTH | Destination register contents |
| zero | output | 1 | High when result is all zeros |

## Verification
Every stored bit is visible on result, so a wrong entry in a per-bit function slice shows up in the cycle right after the first load that drives that slice with the faulty operand pair. The operand patterns are chosen so that each code meets all four operand combinations in every bit position within a few loads. A register that ignores load_en, or a zero flag that drifts from the stored value, shows up at the first idle cycle or the first all-zero result that follows.

// File: rtl/luop_pkg.sv
package luop_pkg;
  // 4-bit function code; each code is its own truth table, so it is indexed by operand bits
  typedef logic [3:0] fcode_t;
  localparam fcode_t FC_CLEAR = 4'd0;
  localparam fcode_t FC_AND   = 4'd1;
  localparam fcode_t FC_PASSA = 4'd3;
  localparam fcode_t FC_SET   = 4'd15;
endpackage

// File: rtl/luop_bitcell.sv
module luop_bitcell
  import luop_pkg::*;
(
  input  fcode_t code,
  input  logic   a,
  input  logic   b,
  output logic   y
);
  logic [1:0] sel;
  // Truth-table lookup (R8): index {~a,~b} into the function code
  assign sel = {~a, ~b};
  assign y   = code[sel];
endmodule

// File: rtl/luop_array.sv
module luop_array
  import luop_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  fcode_t           code,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] y
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    luop_bitcell u_cell (
      .code (code),
      .a    (a[i]),
      .b    (b[i]),
      .y    (y[i])
    );
  end
endmodule

// File: rtl/luop_dest_reg.sv
module luop_dest_reg #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

  a_r1_reset_clears: assert property (@(posedge clk) rst |=> q == '0);
  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));
  a_r10_load_latency: assert property (@(posedge clk) disable iff (rst)
    load |=> q == $past(d));
endmodule

// File: rtl/luop_zero_detect.sv
module luop_zero_detect #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] v,
  output logic             is_zero
);
  assign is_zero = ~(|v);
endmodule

// File: rtl/logic_uop_unit.sv
module logic_uop_unit
  import luop_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [3:0]       func,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic [WIDTH-1:0] result,
  output logic             zero
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic [WIDTH-1:0] fn_out;

  luop_array #(.WIDTH(WIDTH)) u_array (
    .code (fcode_t'(func)),
    .a    (opa),
    .b    (opb),
    .y    (fn_out)
  );

  luop_dest_reg #(.WIDTH(WIDTH)) u_reg (
    .clk  (clk),
    .rst  (rst),
    .load (load_en),
    .d    (fn_out),
    .q    (result)
  );

  luop_zero_detect #(.WIDTH(WIDTH)) u_zero (
    .v       (result),
    .is_zero (zero)
  );

  a_r3_clear_code: assert property (@(posedge clk) disable iff (rst)
    (load_en && func == FC_CLEAR) |=> result == '0);
  a_r3_set_code: assert property (@(posedge clk) disable iff (rst)
    (load_en && func == FC_SET) |=> result == ALL_ONES);
  a_r4_and_code: assert property (@(posedge clk) disable iff (rst)
    (load_en && func == FC_AND) |=> result == ($past(opa) & $past(opb)));
  a_r6_pass_a: assert property (@(posedge clk) disable iff (rst)
    (load_en && func == FC_PASSA) |=> result == $past(opa));
  a_r9_zero_flag: assert property (@(posedge clk) disable iff (rst)
    zero == (result == '0));
endmodule

// File: tb/logic_uop_unit_bench.sv
module logic_uop_unit_bench;
  localparam int W = 16;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic clk = 1'b0;
  logic rst, load_en;
  logic [3:0] func;
  logic [W-1:0] opa, opb, result;
  logic zero;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  logic_uop_unit #(.WIDTH(W)) u_logic_uop_unit (
    .clk(clk), .rst(rst), .load_en(load_en), .func(func),
    .opa(opa), .opb(opb), .result(result), .zero(zero));

  function automatic logic [W-1:0] model(input logic [3:0] f, input logic [W-1:0] a, input logic [W-1:0] b);
    case (f)
      4'd0:  return '0;
      4'd1:  return a & b;
      4'd2:  return a & ~b;
      4'd3:  return a;
      4'd4:  return ~a & b;
      4'd5:  return b;
      4'd6:  return a ^ b;
      4'd7:  return a | b;
      4'd8:  return ~(a | b);
      4'd9:  return ~(a ^ b);
      4'd10: return ~b;
      4'd11: return a | ~b;
      4'd12: return ~a;
      4'd13: return ~a | b;
      4'd14: return ~(a & b);
      default: return ONES;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] f);
    case (f)
      4'd0, 4'd15: return "R3";
      4'd1, 4'd6, 4'd7, 4'd9: return "R4";
      4'd8, 4'd14: return "R5";
      4'd3, 4'd5, 4'd10, 4'd12: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive on falling edge, sample 1 ns after the rising edge
  task automatic do_load(input logic [3:0] f, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    func = f; opa = a; opb = b; load_en = 1'b1;
    @(posedge clk); #1;
    check(req_of(f), result, model(f, a, b));
    check("R9", {{(W-1){1'b0}}, zero}, {{(W-1){1'b0}}, model(f, a, b) == '0});
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] held;
    void'($urandom(32'd7));
    rst = 1'b1; load_en = 1'b0; func = '0; opa = '0; opb = '0;
    repeat (2) @(posedge clk); #1;
    check("R1", result, '0);
    check("R1", {{(W-1){1'b0}}, zero}, {{(W-1){1'b0}}, 1'b1});
    @(negedge clk); rst = 1'b0;

    // R10: one-cycle latency, not zero-cycle
    @(negedge clk);
    func = 4'd15; opa = '0; opb = '0; load_en = 1'b1;
    #1 check("R10", result, '0);
    @(posedge clk); #1 check("R10", result, ONES);

    // exhaustive codes, boundary operands
    for (int f = 0; f < 16; f++) begin
      do_load(4'(f), '0, '0);
      do_load(4'(f), ONES, ONES);
      do_load(4'(f), '0, ONES);
      do_load(4'(f), ONES, '0);
      do_load(4'(f), 16'h5A5A, 16'h0FF0);
      for (int k = 0; k < 12; k++) do_load(4'(f), W'($urandom), W'($urandom));
    end

    // R8: all four operand combinations per nibble -> reversed code
    for (int f = 0; f < 16; f++) begin
      logic [3:0] fv, rv;
      fv = 4'(f);
      rv = {fv[0], fv[1], fv[2], fv[3]};
      @(negedge clk);
      func = fv; opa = 16'hCCCC; opb = 16'hAAAA; load_en = 1'b1;
      @(posedge clk); #1 check("R8", result, {4{rv}});
    end

    // R2: idle cycles keep the value
    do_load(4'd6, 16'h1234, 16'h00FF);
    held = result;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      load_en = 1'b0; func = 4'($urandom); opa = W'($urandom); opb = W'($urandom);
      @(posedge clk); #1 check("R2", result, held);
    end
    // R2: zero flag also held when idle with zero result
    do_load(4'd0, ONES, ONES);
    @(negedge clk); load_en = 1'b0; func = 4'd15;
    @(posedge clk); #1 check("R2", {{(W-1){1'b0}}, zero}, {{(W-1){1'b0}}, 1'b1});

    // R1: reset beats a simultaneous load
    do_load(4'd15, '0, '0);
    @(negedge clk); rst = 1'b1; load_en = 1'b1; func = 4'd15;
    @(posedge clk); #1 check("R1", result, '0);
    @(negedge clk); rst = 1'b0; load_en = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule